// File: doc/BRIEF.md
# Handshaked Signed Fixed-Point Divider

The block divides one signed fixed-point dividend by one signed fixed-point divisor and returns a signed fixed-point quotient. Parameters set the total width and the integer width of each of the three numbers. The quotient is truncated toward zero. An overflow flag marks a zero divisor and any quotient that the result format cannot hold. A parameter chooses whether an overflowing result is clamped or wrapped.

The core is a restoring divider that works on magnitudes and applies the sign at the end. It resolves one quotient bit per pipeline stage. Latency is fixed by the parameters, results come out in input order, and one operation can be accepted every cycle.

Operands enter on a valid signal gated by the block's ready output. That ready output takes effect one cycle late: a low ready in one cycle refuses whatever is offered in the next cycle. On the output side, valid is qualified by the downstream ready, and the whole pipeline holds while downstream is not ready. Optional register stages, one at the operand inputs and one at the result, shorten the logic paths and add one cycle of latency each. A two-entry holding buffer absorbs the operands that arrive during the one-cycle lag of the input ready.

Top module: `fxdiv_hs`

## Requirements
- R1: With integer codes X, Y and Q and SH = (QW-QI) - (XW-XI) + (YW-YI), where SH must not be negative, an in-range result is Q = trunc(X * 2^SH / Y), rounded toward zero for every sign combination.
- R2: A zero divisor sets `out_ovf` to 1 in both modes. The result is then the most negative code when the dividend is negative, and the most positive code otherwise, including for a zero dividend.
- R3: With SATURATE=1, a nonzero-divisor quotient above 2^(QW-1)-1 or below -2^(QW-1) sets `out_ovf` to 1. The result is then the most positive code (0 followed by ones) for a positive quotient, or the most negative code (1 followed by zeros) for a negative one.
- R4: With SATURATE=0, such an out-of-range quotient sets `out_ovf` to 1 and returns the low QW bits of the exact truncated quotient in two's complement.
- R5: With the default formats (XW=12, XI=4, YW=8, YI=4, QW=14, QI=8), the most negative dividend 0x800 divided by the divisor -1 LSB (0xFF) overflows, and in saturate mode returns 8191. Dividend 0x801 divided by the same divisor returns 8188 with no overflow.
- R6: `out_valid` is never 1 while `out_rdy` is 0. While a result waits with `out_rdy` low, `out_q` and `out_ovf` hold their values. No accepted operation is lost, and results leave in the order they were accepted.
- R7: An operand offered with `in_valid` high is accepted exactly when `in_rdy` was 1 in the previous cycle, whatever `out_rdy` is in the offering cycle. Offers made after a cycle with `in_rdy` low produce no result.
- R8: With `out_rdy` held high, a result appears exactly XW+SH+IN_REG+OUT_REG cycles after the clock edge that accepted its operands (15 for both configurations used here). Back-to-back operations give back-to-back results.
- R9: During reset, `out_valid` is 0 and `in_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered this cycle |
| in_x | input | XW | Dividend, signed two's complement with XW-XI fraction bits |
| in_y | input | YW | Divisor, signed two's complement with YW-YI fraction bits |
| in_rdy | output | 1 | Room for an operand pair in the following cycle |
| out_rdy | input | 1 | Downstream can take a result this cycle |
| out_valid | output | 1 | Result presented and taken this cycle |
| out_q | output | QW | Quotient, signed two's complement with QW-QI fraction bits |
| out_ovf | output | 1 | Result overflowed or divisor was zero |

## Verification
Two events can fall in the same cycle: an operand pair that the lagging input ready still admits, and a stall from the downstream side. When they meet, the operands must be parked in the holding buffer rather than lost or duplicated. The bench provokes this with a long phase of dense random offers under random `out_rdy` gaps. It mirrors the one-cycle-late ready rule to decide which offers count, and feeds every counted offer into a scoreboard. Any dropped result, extra result, reordering or wrong value during those coincidences shows up as a mismatch or a leftover queue entry.

// File: rtl/fxdiv_hs.sv
module fxdiv_hs #(
  parameter int XW = 12,
  parameter int XI = 4,
  parameter int YW = 8,
  parameter int YI = 4,
  parameter int QW = 14,
  parameter int QI = 8,
  parameter bit SATURATE = 1'b1,
  parameter bit IN_REG = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  output logic          in_rdy,
  input  logic          out_rdy,
  output logic          out_valid,
  output logic [QW-1:0] out_q,
  output logic          out_ovf
);

  localparam int SH = (QW - QI) - (XW - XI) + (YW - YI);
  localparam int NW = XW + SH;
  localparam int MW = (NW > QW ? NW : QW) + 1;
  localparam logic [MW-1:0] LIMP = MW'(1) << (QW - 1);
  localparam logic [QW-1:0] QMAXC = {1'b0, {(QW-1){1'b1}}};
  localparam logic [QW-1:0] QMINC = {1'b1, {(QW-1){1'b0}}};

  logic adv, take, rdy_q, hv;
  logic [1:0] cnt;
  logic [XW-1:0] bx0, bx1, hx;
  logic [YW-1:0] by0, by1, hy;

  assign adv    = out_rdy;
  assign in_rdy = (cnt == 2'd0);
  assign take   = in_valid & rdy_q;
  assign hv     = (cnt != 2'd0) | take;
  assign hx     = (cnt != 2'd0) ? bx0 : in_x;
  assign hy     = (cnt != 2'd0) ? by0 : in_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= in_rdy;
      if (adv && cnt != 2'd0) begin
        if (cnt == 2'd2) cnt <= 2'd1;
        else if (!take) cnt <= 2'd0;
      end else if (!adv && take) begin
        cnt <= (cnt == 2'd0) ? 2'd1 : 2'd2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv && cnt != 2'd0) begin
      if (cnt == 2'd2) begin
        bx0 <= bx1;
        by0 <= by1;
      end else if (take) begin
        bx0 <= in_x;
        by0 <= in_y;
      end
    end else if (!adv && take) begin
      if (cnt == 2'd0) begin
        bx0 <= in_x;
        by0 <= in_y;
      end else begin
        bx1 <= in_x;
        by1 <= in_y;
      end
    end
  end

  logic pv;
  logic [XW-1:0] px;
  logic [YW-1:0] py;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv <= 1'b0;
        else if (adv) pv <= hv;
      end
      always_ff @(posedge clk) begin
        if (adv) begin
          px <= hx;
          py <= hy;
        end
      end
    end else begin : g_in_wire
      assign pv = hv;
      assign px = hx;
      assign py = hy;
    end
  endgenerate

  logic xneg, yneg;
  logic [XW-1:0] xmag;
  logic [YW-1:0] ymag;
  logic [NW-1:0] num;

  assign xneg = px[XW-1];
  assign yneg = py[YW-1];
  assign xmag = xneg ? (~px + 1'b1) : px;
  assign ymag = yneg ? (~py + 1'b1) : py;
  assign num  = NW'(xmag) << SH;

  logic          sv    [0:NW];
  logic [NW-1:0] sn    [0:NW];
  logic          sneg  [0:NW];
  logic          szero [0:NW];
  logic          sxn   [0:NW];
  logic [YW-1:0] sr    [0:NW-1];
  logic [YW-1:0] sd    [0:NW-1];
  logic [YW-1:0] nr    [0:NW-1];
  logic [NW-1:0] nn    [0:NW-1];

  always_comb begin : p_step
    logic [YW:0] tr, df;
    for (int k = 0; k < NW; k++) begin
      tr    = {sr[k], sn[k][NW-1]};
      df    = tr - {1'b0, sd[k]};
      nr[k] = df[YW] ? tr[YW-1:0] : df[YW-1:0];
      nn[k] = {sn[k][NW-2:0], ~df[YW]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= NW; k++) sv[k] <= 1'b0;
    end else if (adv) begin
      sv[0] <= pv;
      for (int k = 0; k < NW; k++) sv[k+1] <= sv[k];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      sr[0]    <= '0;
      sd[0]    <= ymag;
      sn[0]    <= num;
      sneg[0]  <= xneg ^ yneg;
      szero[0] <= (py == '0);
      sxn[0]   <= xneg;
      for (int k = 0; k < NW; k++) begin
        sn[k+1]    <= nn[k];
        sneg[k+1]  <= sneg[k];
        szero[k+1] <= szero[k];
        sxn[k+1]   <= sxn[k];
      end
      for (int k = 1; k < NW; k++) begin
        sr[k] <= nr[k-1];
        sd[k] <= sd[k-1];
      end
    end
  end

  logic [MW-1:0] qmx;
  logic [QW-1:0] qlo, qsg, fq;
  logic big, fovf, fv, last_v;

  assign qmx  = MW'(sn[NW]);
  assign big  = sneg[NW] ? (qmx > LIMP) : (qmx >= LIMP);
  assign qlo  = qmx[QW-1:0];
  assign qsg  = sneg[NW] ? (~qlo + 1'b1) : qlo;
  assign fv   = sv[NW];
  assign fovf = szero[NW] | big;
  assign fq   = szero[NW] ? (sxn[NW] ? QMINC : QMAXC) :
                (big && SATURATE) ? (sneg[NW] ? QMINC : QMAXC) : qsg;

  generate
    if (OUT_REG) begin : g_out_reg
      logic ov, oo;
      logic [QW-1:0] oq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ov <= 1'b0;
        else if (adv) ov <= fv;
      end
      always_ff @(posedge clk) begin
        if (adv) begin
          oq <= fq;
          oo <= fovf;
        end
      end
      assign last_v  = ov;
      assign out_q   = oq;
      assign out_ovf = oo;
    end else begin : g_out_wire
      assign last_v  = fv;
      assign out_q   = fq;
      assign out_ovf = fovf;
    end
  endgenerate

  assign out_valid = last_v & out_rdy;

  // R6
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |-> !out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_v && !out_rdy) |=> (last_v && $stable(out_q) && $stable(out_ovf)));

  // R7
  buf_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt != 2'd2));

  // R3
  sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf && SATURATE) |-> (out_q == QMAXC || out_q == QMINC));

endmodule

// File: tb/fxdiv_hs_tb.sv
module fxdiv_hs_tb;
  localparam int LAT = 15;
  localparam int SHB = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [11:0] in_x = '0;
  logic [7:0] in_y = '0;
  logic out_rdy = 1'b1;
  logic rdy_a, rdy_b, ov_a, ov_b, of_a, of_b;
  logic [13:0] q_a;
  logic [9:0] q_b;

  fxdiv_hs u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_rdy(rdy_a), .out_rdy(out_rdy), .out_valid(ov_a), .out_q(q_a), .out_ovf(of_a)
  );

  fxdiv_hs #(.XW(12), .XI(4), .YW(8), .YI(4), .QW(10), .QI(4),
             .SATURATE(1'b0), .IN_REG(1'b1), .OUT_REG(1'b0)) u_dut_wrap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_rdy(rdy_b), .out_rdy(out_rdy), .out_valid(ov_b), .out_q(q_b), .out_ovf(of_b)
  );

  typedef struct {
    longint x;
    longint y;
    longint q;
    bit     ovf;
    longint t0;
    bit     tl;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];
  exp_t ea, eb;

  int checks = 0, errors = 0, dropped = 0, pushed = 0, got_a = 0, got_b = 0;
  longint cyc = 0;
  bit prev_rdy = 1'b0, cur_rdy = 1'b0, lat_mode = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model(input longint x, input longint y, input int qw,
                                input bit sat, output longint q, output bit ovf);
    longint qmax, qmin, t, m;
    qmax = (longint'(1) <<< (qw - 1)) - 1;
    qmin = -(longint'(1) <<< (qw - 1));
    if (y == 0) begin
      ovf = 1'b1;
      q = (x < 0) ? qmin : qmax;
    end else begin
      t = (x * (longint'(1) <<< SHB)) / y;
      if (t > qmax || t < qmin) begin
        ovf = 1'b1;
        if (sat) q = (t < 0) ? qmin : qmax;
        else begin
          m = t & ((longint'(1) <<< qw) - 1);
          if (m > qmax) m = m - (longint'(1) <<< qw);
          q = m;
        end
      end else begin
        ovf = 1'b0;
        q = t;
      end
    end
  endfunction

  function automatic string tag_of(input longint x, input longint y, input bit ovf, input bit sat);
    if (y == 0) return "R2";
    if (x == -2048 && y == -1) return "R5";
    if (ovf) return sat ? "R3" : "R4";
    return "R1";
  endfunction

  task automatic push(input logic [11:0] x, input logic [7:0] y);
    exp_t e;
    e.x  = longint'($signed(x));
    e.y  = longint'($signed(y));
    e.t0 = cyc + 1;
    e.tl = lat_mode;
    model(e.x, e.y, 14, 1'b1, e.q, e.ovf);
    qa.push_back(e);
    model(e.x, e.y, 10, 1'b0, e.q, e.ovf);
    qb.push_back(e);
    pushed++;
  endtask

  task automatic cycle(input bit v, input logic [11:0] x, input logic [7:0] y, input bit r);
    @(negedge clk);
    prev_rdy = cur_rdy;
    cur_rdy  = rdy_a & rdy_b;
    in_valid = v;
    in_x     = x;
    in_y     = y;
    out_rdy  = r;
    if (v) begin
      if (prev_rdy) push(x, y);
      else dropped++;
    end
  endtask

  task automatic judge(input string name, input bit sat, input exp_t e,
                       input longint gq, input bit gov);
    string t;
    t = tag_of(e.x, e.y, e.ovf, sat);
    checks++;
    if (gq != e.q || gov != e.ovf) begin
      errors++;
      $display("FAIL %s %s x=%0d y=%0d: got q=%0d ovf=%0d expected q=%0d ovf=%0d",
               t, name, e.x, e.y, gq, gov, e.q, e.ovf);
    end
    if (e.tl) begin
      checks++;
      if (cyc - e.t0 != LAT) begin
        errors++;
        $display("FAIL R8 %s latency: got %0d expected %0d", name, cyc - e.t0, LAT);
      end
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (!out_rdy) begin
        checks++;
        if (ov_a || ov_b) begin
          errors++;
          $display("FAIL R6 valid while not ready: got %0d/%0d expected 0/0", ov_a, ov_b);
        end
      end
      if (ov_a) begin
        got_a++;
        if (qa.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 sat unexpected result: got q=%0d expected none", $signed(q_a));
        end else begin
          ea = qa.pop_front();
          judge("sat", 1'b1, ea, longint'($signed(q_a)), of_a);
        end
      end
      if (ov_b) begin
        got_b++;
        if (qb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 wrap unexpected result: got q=%0d expected none", $signed(q_b));
        end else begin
          eb = qb.pop_front();
          judge("wrap", 1'b0, eb, longint'($signed(q_b)), of_b);
        end
      end
    end
  end

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: got no finish after %0d cycles expected finish", cyc);
    report();
  end

  logic [11:0] dx [12] = '{12'h100, 12'hFFF, 12'h001, 12'h800, 12'h801, 12'h7FF,
                           12'h800, 12'h064, 12'hF9C, 12'h000, 12'h000, 12'hD00};
  logic [7:0]  dy [12] = '{8'h10, 8'h03, 8'hFD, 8'hFF, 8'hFF, 8'h01,
                           8'h01, 8'h00, 8'h00, 8'h00, 8'h05, 8'h20};

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    // R9 reset state
    if (ov_a || ov_b || !rdy_a || !rdy_b) begin
      errors++;
      $display("FAIL R9 reset: got valid=%0d/%0d rdy=%0d/%0d expected 0/0 1/1",
               ov_a, ov_b, rdy_a, rdy_b);
    end
    rst_n = 1'b1;
    repeat (2) cycle(1'b0, '0, '0, 1'b1);

    lat_mode = 1'b1;
    for (int i = 0; i < 12; i++) begin
      cycle(1'b1, dx[i], dy[i], 1'b1);
      cycle(1'b0, '0, '0, 1'b1);
    end
    for (int i = 0; i < 40; i++) cycle(1'b1, 12'($urandom), 8'($urandom), 1'b1);
    repeat (LAT + 5) cycle(1'b0, '0, '0, 1'b1);

    lat_mode = 1'b0;
    for (int i = 0; i < 600; i++) begin
      logic [11:0] x;
      logic [7:0] y;
      int s;
      s = $urandom % 20;
      x = 12'($urandom);
      y = 8'($urandom);
      if (s < 2) y = 8'h00;
      else if (s == 2) begin x = 12'h800; y = 8'hFF; end
      cycle(($urandom % 10) < 7, x, y, ($urandom % 4) != 0);
    end
    repeat (LAT + 10) cycle(1'b0, '0, '0, 1'b1);

    checks++;
    // R6 nothing lost or stuck
    if (qa.size() != 0 || qb.size() != 0 || got_a != pushed || got_b != pushed) begin
      errors++;
      $display("FAIL R6 drain: got %0d/%0d results expected %0d", got_a, got_b, pushed);
    end
    checks++;
    // R7 late-ready refusals were exercised
    if (dropped == 0) begin
      errors++;
      $display("FAIL R7 refused offers: got %0d expected more than 0", dropped);
    end
    report();
  end
endmodule